// File: doc/BRIEF.md
# Lower-part OR approximate adder

This block adds two unsigned operands of `WIDTH` bits while deliberately giving up exactness in the least significant `LOW` bits. Those bits are not added at all. Each one is the OR of the two operand bits at that position, so there is no carry ripple through them. The remaining `WIDTH-LOW` upper bits are produced by an exact parallel-prefix adder. Its carry-in is the AND of the two operand bits at position `LOW-1`. That single gate is a cheap guess at the carry that an exact lower adder would have produced.

The block is purely combinational. It suits datapaths that tolerate error, such as filter accumulators and learning-rate updates, where a small error in the low-order bits is acceptable in exchange for a shorter carry chain and fewer cells. The split point is fixed at elaboration through the `LOW` parameter. A value of 0 yields an exact adder, and a value equal to `WIDTH` yields a pure OR with no carry.

Top module: `loa_adder`

## Requirements
- R1: For every bit position i below `LOW`, `sum_out[i]` is 1 exactly when `a_in[i]` or `b_in[i]` is 1.
- R2: `sum_out[WIDTH-1:LOW]` is the low `WIDTH-LOW` bits of the exact sum of `a_in[WIDTH-1:LOW]`, `b_in[WIDTH-1:LOW]` and the upper carry-in.
- R3: When 0 < `LOW` < `WIDTH`, the upper carry-in is `a_in[LOW-1] & b_in[LOW-1]`.
- R4: `carry_out` is the carry leaving the upper exact adder, i.e. bit `WIDTH` of the value {carry_out, sum_out}.
- R5: When `a_in[LOW-1:0] & b_in[LOW-1:0]` is zero, {carry_out, sum_out} equals the exact sum `a_in + b_in`.
- R6: The signed difference between {carry_out, sum_out} and the exact sum `a_in + b_in` lies between -(2^(LOW-1) - 1) and +2^(LOW-1) inclusive, for 0 < `LOW` < `WIDTH`.
- R7: With `LOW` = 0, {carry_out, sum_out} equals `a_in + b_in` exactly.
- R8: With `LOW` = `WIDTH`, `sum_out` is `a_in | b_in` and `carry_out` is 0.
- R9: The outputs depend only on the present inputs and hold no state: zero operands give a zero sum and a zero carry.
- R10: Split points of 2, 6 and 16 on a 20-bit adder each follow R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| sum_out | output | WIDTH | Approximate sum: OR lane below `LOW`, exact sum above |
| carry_out | output | 1 | Carry out of the upper exact adder |

## Verification
Every result of this block is due in the same cycle as its operands, because no register lies between the inputs and the outputs. The bench changes the operands on the falling clock edge. It then samples the outputs 1 ns later, well before the next rising edge, so no check depends on which process runs first at an edge. Five instances with different split points share the same operands, and each instance is compared with a model built from the requirements. The bench also records how many results in the 6-bit-split configuration differ from the exact sum, and the largest error it sees.

// File: rtl/loa_pkg.sv
// Package: shared definitions for the lower-part OR adder.
// Assumes: the split point never exceeds the operand width.
package loa_pkg;

    // Structural variant chosen from the split point at elaboration.
    typedef enum logic [1:0] {
        LOA_EXACT   = 2'd0,
        LOA_SPLIT   = 2'd1,
        LOA_OR_ONLY = 2'd2
    } loa_variant_e;

    // Picks the variant that matches a given width and split point.
    function automatic loa_variant_e loa_pick_variant(input int width, input int low);
        if (low <= 0)
            return LOA_EXACT;
        else if (low >= width)
            return LOA_OR_ONLY;
        else
            return LOA_SPLIT;
    endfunction

endpackage

// File: rtl/loa_or_lane.sv
// Module: loa_or_lane
// Forms the approximate low-order sum bits. Each bit is the OR of the
// two operand bits at that position, so no carry runs through the lane.
// Assumes: W >= 1.
module loa_or_lane #(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    // One OR gate per bit position; the bits are independent of each other.
    for (genvar k = 0; k < W; k++) begin : g_or
        assign sum_o[k] = a_i[k] | b_i[k];
    end

endmodule

// File: rtl/loa_prefix_adder.sv
// Module: loa_prefix_adder
// Exact W-bit adder with a carry-in. Carries are built by a parallel-prefix
// (Kogge-Stone style) tree, so the logic depth grows with log2(W).
// Assumes: W >= 1; the operands are unsigned.
module loa_prefix_adder #(
    parameter int W = 14
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int LV = (W > 1) ? $clog2(W) : 1;

    logic [LV:0][W-1:0] gen_t;
    logic [LV:0][W-1:0] prp_t;
    logic [W:0]         carry;

    // Level 0: generate and propagate terms for each bit.
    assign gen_t[0] = a_i & b_i;
    assign prp_t[0] = a_i ^ b_i;

    // Prefix levels: at each level a bit merges with the group 2^(lv-1) below it.
    for (genvar lv = 1; lv <= LV; lv++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= (1 << (lv - 1))) begin : g_merge
                assign gen_t[lv][i] = gen_t[lv-1][i]
                                    | (prp_t[lv-1][i] & gen_t[lv-1][i-(1<<(lv-1))]);
                assign prp_t[lv][i] = prp_t[lv-1][i] & prp_t[lv-1][i-(1<<(lv-1))];
            end else begin : g_pass
                assign gen_t[lv][i] = gen_t[lv-1][i];
                assign prp_t[lv][i] = prp_t[lv-1][i];
            end
        end
    end

    // Carry into each bit: group generate, or group propagate of the carry-in.
    assign carry[0] = cin_i;
    for (genvar i = 0; i < W; i++) begin : g_carry
        assign carry[i+1] = gen_t[LV][i] | (prp_t[LV][i] & cin_i);
    end

    // Final sum and carry-out.
    assign sum_o  = prp_t[0] ^ carry[W-1:0];
    assign cout_o = carry[W];

    // Checks the prefix tree against a behavioural sum.
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_UPPER_EXACT: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
                else $error("upper prefix adder result wrong"); // R2
        end
    end

endmodule

// File: rtl/loa_adder.sv
// Module: loa_adder (top)
// Approximate unsigned adder. Bits below LOW come from an OR lane. Bits
// from LOW upward come from an exact prefix adder whose carry-in is the
// AND of the operand bits at LOW-1. LOW = 0 gives an exact adder and
// LOW = WIDTH gives a pure OR with no carry-out.
// Assumes: 0 <= LOW <= WIDTH; purely combinational, so no clock or reset.
module loa_adder
    import loa_pkg::*;
#(
    parameter int WIDTH = 20,
    parameter int LOW   = 6
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam loa_variant_e VARIANT = loa_pick_variant(WIDTH, LOW);
    localparam int           HI_W    = WIDTH - LOW;

    if (VARIANT == LOA_EXACT) begin : g_exact
        // Whole word goes through the exact adder with no carry-in.
        loa_prefix_adder #(.W(WIDTH)) u_full (
            .a_i    (a_in),
            .b_i    (b_in),
            .cin_i  (1'b0),
            .sum_o  (sum_out),
            .cout_o (carry_out)
        );

        // Checks the degenerate exact configuration.
        always_comb begin
            if (!$isunknown({a_in, b_in})) begin
                AST_FULL_EXACT: assert ({carry_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in}))
                    else $error("LOW=0 result not exact"); // R7
            end
        end
    end else if (VARIANT == LOA_OR_ONLY) begin : g_or_only
        // Whole word goes through the OR lane; nothing carries out.
        loa_or_lane #(.W(WIDTH)) u_lane (
            .a_i   (a_in),
            .b_i   (b_in),
            .sum_o (sum_out)
        );
        assign carry_out = 1'b0;

        // Checks the degenerate OR-only configuration.
        always_comb begin
            if (!$isunknown({a_in, b_in})) begin
                AST_FULL_OR: assert (((sum_out & ~(a_in | b_in)) == '0)
                                  && (((a_in | b_in) & ~sum_out) == '0))
                    else $error("LOW=WIDTH sum is not the OR"); // R8
            end
        end
    end else begin : g_split
        localparam logic signed [WIDTH+2:0] ERR_MAX = (WIDTH+3)'(1) << (LOW - 1);

        logic [LOW-1:0]    lo_sum;
        logic [HI_W-1:0]   hi_sum;
        logic              hi_cin;
        logic [WIDTH:0]    exact_tot;
        logic [WIDTH:0]    approx_tot;
        logic [WIDTH:0]    hi_ref;
        logic signed [WIDTH+2:0] err;

        // Carry guess into the upper adder from the top pair of the lower bits.
        assign hi_cin = a_in[LOW-1] & b_in[LOW-1];

        loa_or_lane #(.W(LOW)) u_lane (
            .a_i   (a_in[LOW-1:0]),
            .b_i   (b_in[LOW-1:0]),
            .sum_o (lo_sum)
        );

        loa_prefix_adder #(.W(HI_W)) u_upper (
            .a_i    (a_in[WIDTH-1:LOW]),
            .b_i    (b_in[WIDTH-1:LOW]),
            .cin_i  (hi_cin),
            .sum_o  (hi_sum),
            .cout_o (carry_out)
        );

        // Result word: exact upper field above the OR lane.
        assign sum_out = {hi_sum, lo_sum};

        // Values compared by the assertions below.
        assign exact_tot  = {1'b0, a_in} + {1'b0, b_in};
        assign approx_tot = {carry_out, sum_out};
        assign hi_ref     = ({1'b0, a_in} >> LOW) + ({1'b0, b_in} >> LOW)
                          + {{WIDTH{1'b0}}, a_in[LOW-1] & b_in[LOW-1]};
        assign err        = $signed({2'b00, approx_tot}) - $signed({2'b00, exact_tot});

        // Checks the split configuration at the ports.
        always_comb begin
            if (!$isunknown({a_in, b_in})) begin
                AST_LOW_OR: assert (((sum_out[LOW-1:0] & ~(a_in[LOW-1:0] | b_in[LOW-1:0])) == '0)
                                 && (((a_in[LOW-1:0] | b_in[LOW-1:0]) & ~sum_out[LOW-1:0]) == '0))
                    else $error("low bits are not the OR"); // R1
                AST_UPPER_CARRY: assert ((approx_tot >> LOW) == hi_ref)
                    else $error("upper field or carry-in wrong"); // R3
                AST_EXACT_NO_OVERLAP: assert (((a_in[LOW-1:0] & b_in[LOW-1:0]) != '0)
                                           || (approx_tot == exact_tot))
                    else $error("non-overlapping low bits gave an inexact sum"); // R5
                AST_ERR_BOUND: assert ((err <= ERR_MAX) && (err > -ERR_MAX))
                    else $error("error outside bound"); // R6
            end
        end
    end

endmodule

// File: tb/loa_adder_tb.sv
`timescale 1ns/1ps
// Bench for loa_adder: vector table on the 6-bit split, a pseudo-random
// sweep against a model written from the requirements, then directed
// checks on the degenerate split points.
module loa_adder_tb;

    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] a_r = '0;
    logic [TW-1:0] b_r = '0;

    logic [TW-1:0] s6, s2, s16, s0, sn;
    logic          c6, c2, c16, c0, cn;

    int n_chk  = 0;
    int n_fail = 0;
    int n_diff = 0;
    int max_err = 0;

    always #2 clk = ~clk;

    loa_adder #(.WIDTH(TW), .LOW(6))  u_dut     (.a_in(a_r), .b_in(b_r), .sum_out(s6),  .carry_out(c6));
    loa_adder #(.WIDTH(TW), .LOW(2))  u_dut_l2  (.a_in(a_r), .b_in(b_r), .sum_out(s2),  .carry_out(c2));
    loa_adder #(.WIDTH(TW), .LOW(16)) u_dut_l16 (.a_in(a_r), .b_in(b_r), .sum_out(s16), .carry_out(c16));
    loa_adder #(.WIDTH(TW), .LOW(0))  u_dut_l0  (.a_in(a_r), .b_in(b_r), .sum_out(s0),  .carry_out(c0));
    loa_adder #(.WIDTH(TW), .LOW(TW)) u_dut_ln  (.a_in(a_r), .b_in(b_r), .sum_out(sn),  .carry_out(cn));

    // Vector table for the 6-bit split: {a, b, expected sum, expected carry}.
    localparam logic [60:0] VEC [9] = '{
        {20'h00000, 20'h00000, 20'h00000, 1'b0},
        {20'h0003F, 20'h00000, 20'h0003F, 1'b0},
        {20'h00020, 20'h00020, 20'h00060, 1'b0},
        {20'h0001F, 20'h0001F, 20'h0001F, 1'b0},
        {20'hFFFFF, 20'h00001, 20'hFFFFF, 1'b0},
        {20'hFFFC0, 20'h00040, 20'h00000, 1'b1},
        {20'hFFFE0, 20'h00020, 20'h00020, 1'b1},
        {20'h12345, 20'h0ABCD, 20'h1CF0D, 1'b0},
        {20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1}
    };

    // Model from the requirements: OR below low, exact above with the pair carry.
    function automatic logic [TW:0] model(input logic [TW-1:0] a, input logic [TW-1:0] b, input int low);
        logic [TW-1:0] mask;
        logic          c;
        logic [TW:0]   hi;
        mask = (low == 0) ? '0 : ({TW{1'b1}} >> (TW - low));
        c = 1'b0;
        if (low > 0 && low < TW) c = a[low-1] & b[low-1];
        hi = ({1'b0, a} >> low) + ({1'b0, b} >> low) + {{TW{1'b0}}, c};
        return (hi << low) | {1'b0, (a | b) & mask};
    endfunction

    // Records one check; prints a FAIL line when it does not hold.
    task automatic check(input bit ok, input string req, input logic [TW:0] act, input logic [TW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives operands on the falling edge and lets the combinational result settle.
    task automatic apply(input logic [TW-1:0] a, input logic [TW-1:0] b);
        @(negedge clk);
        a_r = a;
        b_r = b;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [TW:0] exp_t, act_t;
        int          e;

        // R9: reset period with zero operands gives zero outputs.
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(s6 == '0 && c6 == 1'b0, "R9 zero operands", {c6, s6}, '0);
        rst_n = 1'b1;

        // Vector table, 6-bit split (R1 R2 R3 R4).
        for (int i = 0; i < 9; i++) begin
            apply(VEC[i][60:41], VEC[i][40:21]);
            check({c6, s6} == {VEC[i][0], VEC[i][20:1]}, "R2 table vector", {c6, s6}, {VEC[i][0], VEC[i][20:1]});
        end

        // R6 upper bound reached: 0x20+0x20 is exact 0x40, approximate 0x60.
        apply(20'h00020, 20'h00020);
        e = int'({c6, s6}) - 32'h40;
        check(e == 32, "R6 max positive error", 21'(e), 21'd32);
        // R6 lower bound reached: 0x1F+0x1F is exact 0x3E, approximate 0x1F.
        apply(20'h0001F, 20'h0001F);
        e = int'({c6, s6}) - 32'h3E;
        check(e == -31, "R6 max negative error", 21'(-e), 21'd31);
        // R4: carry leaves the top through the upper adder only.
        apply(20'hFFFC0, 20'h00040);
        check(c6 == 1'b1, "R4 carry_out set", {20'h0, c6}, 21'd1);
        // R3: pair carry ripples all the way to carry_out.
        apply(20'hFFFE0, 20'h00020);
        check({c6, s6} == 21'h100020, "R3 pair carry into upper", {c6, s6}, 21'h100020);

        // Pseudo-random sweep against the model.
        lfsr = 32'h1ACE_B00C;
        for (int it = 0; it < 1500; it++) begin
            logic [TW-1:0] a, b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr[TW-1:0];
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr[TW-1:0];
            if (it % 4 == 0) b[5:0] = b[5:0] & ~a[5:0];
            apply(a, b);

            exp_t = model(a, b, 6);
            act_t = {c6, s6};
            check(act_t == exp_t, "R2 sweep LOW=6", act_t, exp_t);
            check({c2, s2} == model(a, b, 2), "R10 sweep LOW=2", {c2, s2}, model(a, b, 2));
            check({c16, s16} == model(a, b, 16), "R10 sweep LOW=16", {c16, s16}, model(a, b, 16));

            e = int'(act_t) - int'({1'b0, a} + {1'b0, b});
            if (e != 0) n_diff++;
            if (e > max_err) max_err = e;
            if (-e > max_err) max_err = -e;
            check(e <= 32 && e >= -31, "R6 error bound", 21'(e < 0 ? -e : e), 21'd32);
            if ((a[5:0] & b[5:0]) == 6'd0)
                check(act_t == {1'b0, a} + {1'b0, b}, "R5 no shared low bits", act_t, {1'b0, a} + {1'b0, b});
        end
        $display("INFO LOW=6 sweep: %0d of 1500 results differ, max |error| %0d", n_diff, max_err);

        // R7: LOW=0 is an exact adder, including the carry out.
        apply(20'hFFFFF, 20'h00001);
        check({c0, s0} == 21'h100000, "R7 exact overflow", {c0, s0}, 21'h100000);
        apply(20'h12345, 20'h0ABCD);
        check({c0, s0} == 21'h1CF12, "R7 exact sum", {c0, s0}, 21'h1CF12);

        // R8: LOW=WIDTH is a pure OR with no carry.
        apply(20'hFFFFF, 20'hFFFFF);
        check({cn, sn} == 21'h0FFFFF, "R8 all ones", {cn, sn}, 21'h0FFFFF);
        apply(20'hA0F0F, 20'h05F00);
        check({cn, sn} == 21'h0A5F0F, "R8 mixed", {cn, sn}, 21'h0A5F0F);

        // R1: lower lane bits are the OR, shown on LOW=16.
        apply(20'h0F0F0, 20'h00F0F);
        check(s16[15:0] == 16'hFFFF, "R1 low OR LOW=16", {5'h0, s16[15:0]}, 21'h0FFFF);

        // R9: returning to zero operands clears the outputs.
        apply(20'h00000, 20'h00000);
        check({c6, s6} == '0 && {c2, s2} == '0, "R9 back to zero", {c6, s6}, '0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule